// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This unit sits in the execute stage of a 64-bit integer pipeline. For each instruction word it decides where the program counter goes next and whether a return address must be written. It covers the six conditional branch compares, the PC-relative direct jump and the register-indirect jump. It takes the raw 32-bit instruction, the current PC and two source operand values. It decodes the opcode and the minor opcode itself and builds the immediates it needs from the instruction bits.

All outputs are registered, so results appear one clock after the inputs are sampled. An instruction that is not a control transfer passes through with a sequential next PC and no link write. Encodings inside the branch or indirect-jump opcode space that name no valid operation raise an illegal flag. Such an encoding takes no control-flow action.

Top module: `bju_next_pc`

## Requirements
- R1: While reset is active (rst_n low), and at the first clock edge after it, next_pc, taken, link_we, link_val and illegal are all zero.
- R2: With opcode bits [6:0]=0x63, minor opcode bits [14:12]=0 is taken when src_a equals src_b, and minor opcode 1 is taken when they differ.
- R3: With opcode 0x63, minor opcode 4 is taken when src_a is less than src_b as two's-complement numbers, and minor opcode 5 is taken when src_a is greater than or equal to src_b as two's-complement numbers.
- R4: With opcode 0x63, minor opcode 6 is taken when src_a is less than src_b as unsigned numbers, and minor opcode 7 is taken when src_a is greater than or equal to src_b as unsigned numbers.
- R5: A taken branch sets next_pc to pc plus the sign-extended branch offset. The offset takes bit 12 from insn[31], bit 11 from insn[7], bits 10:5 from insn[30:25] and bits 4:1 from insn[11:8], with bit 0 zero.
- R6: A not-taken branch, and any opcode other than 0x63, 0x67 and 0x6f, gives next_pc = pc + 4 with taken low.
- R7: A conditional branch never asserts link_we. Whenever link_we is low, link_val is zero.
- R8: Opcode 0x6f is always taken, with next_pc = pc plus the sign-extended jump offset, link_we high and link_val = pc + 4. The offset takes bit 20 from insn[31], bits 19:12 from insn[19:12], bit 11 from insn[20] and bits 10:1 from insn[30:21], with bit 0 zero.
- R9: Opcode 0x67 with minor opcode 0 is always taken. Its next_pc is src_a plus the sign-extended insn[31:20], with bit 0 of the sum forced to zero. It sets link_we high and link_val = pc + 4.
- R10: Opcode 0x63 with minor opcode 2 or 3, and opcode 0x67 with a nonzero minor opcode, set illegal. These encodings keep taken and link_we low and give next_pc = pc + 4. Every other encoding keeps illegal low.
- R11: Outputs present the result for the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_i | input | 32 | Instruction word |
| pc_i | input | 64 | Address of the instruction |
| src_a_i | input | 64 | First source operand |
| src_b_i | input | 64 | Second source operand |
| next_pc_o | output | 64 | Address of the next instruction |
| taken_o | output | 1 | Control transfer leaves the sequential path |
| link_we_o | output | 1 | Return address must be written |
| link_val_o | output | 64 | Return address value |
| illegal_o | output | 1 | Invalid encoding in the control-transfer opcode space |

## Verification
A wrong compare shows up one cycle after the operands are applied, as a taken flag of the wrong sense. The error is most visible when the operands straddle the sign boundary, where the signed and unsigned orderings disagree. An offset bit wired to the wrong instruction bit shows in next_pc on the very next cycle, but only when the stimulus sets that bit. Random offsets are therefore combined with the extreme offsets. A missing mask on the indirect target shows as an odd next_pc, and only when the operand and the offset sum to an odd value.

// File: rtl/bju_pkg.sv
package bju_pkg;

  localparam logic [6:0] OPC_BRANCH = 7'h63;
  localparam logic [6:0] OPC_IJUMP  = 7'h67;
  localparam logic [6:0] OPC_DJUMP  = 7'h6f;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_NE  = 3'd1,
    CMP_RS2 = 3'd2,
    CMP_RS3 = 3'd3,
    CMP_LT  = 3'd4,
    CMP_GE  = 3'd5,
    CMP_LTU = 3'd6,
    CMP_GEU = 3'd7
  } cmp_e;

  typedef enum logic [1:0] {
    K_SEQ    = 2'd0,
    K_BRANCH = 2'd1,
    K_DJUMP  = 2'd2,
    K_IJUMP  = 2'd3
  } kind_e;

  // Branch offset, sign-extended to 32 bits
  function automatic logic [31:0] off_branch(input logic [31:0] w);
    return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  // Direct jump offset, sign-extended to 32 bits
  function automatic logic [31:0] off_jump(input logic [31:0] w);
    return {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
  endfunction

  // Indirect jump offset, sign-extended to 32 bits
  function automatic logic [31:0] off_ind(input logic [31:0] w);
    return {{20{w[31]}}, w[31:20]};
  endfunction

endpackage

// File: rtl/bju_decode.sv
module bju_decode
  import bju_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [31:0]     insn,
  output kind_e           kind,
  output cmp_e            cmp,
  output logic            bad_enc,
  output logic [XLEN-1:0] imm_b,
  output logic [XLEN-1:0] imm_j,
  output logic [XLEN-1:0] imm_i
);

  logic [6:0]  opc;
  logic [2:0]  f3;
  logic [31:0] ob, oj, oi;

  assign opc = insn[6:0];
  assign f3  = insn[14:12];
  assign cmp = cmp_e'(f3);
  assign ob  = off_branch(insn);
  assign oj  = off_jump(insn);
  assign oi  = off_ind(insn);

  generate
    if (XLEN > 32) begin : g_wide
      assign imm_b = {{(XLEN-32){ob[31]}}, ob};
      assign imm_j = {{(XLEN-32){oj[31]}}, oj};
      assign imm_i = {{(XLEN-32){oi[31]}}, oi};
    end else begin : g_narrow
      assign imm_b = ob[XLEN-1:0];
      assign imm_j = oj[XLEN-1:0];
      assign imm_i = oi[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    kind    = K_SEQ;
    bad_enc = 1'b0;
    unique case (opc)
      OPC_BRANCH: begin
        if (f3 == CMP_RS2 || f3 == CMP_RS3) bad_enc = 1'b1;
        else                                kind    = K_BRANCH;
      end
      OPC_DJUMP: kind = K_DJUMP;
      OPC_IJUMP: begin
        if (f3 == 3'd0) kind    = K_IJUMP;
        else            bad_enc = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bju_cond_eval.sv
module bju_cond_eval
  import bju_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  cmp_e            cmp,
  output logic            hit
);

  logic eq, lt_s, lt_u;

  assign eq   = (a == b);
  assign lt_s = ($signed(a) < $signed(b));
  assign lt_u = (a < b);

  always_comb begin
    unique case (cmp)
      CMP_EQ:  hit = eq;
      CMP_NE:  hit = !eq;
      CMP_LT:  hit = lt_s;
      CMP_GE:  hit = !lt_s;
      CMP_LTU: hit = lt_u;
      CMP_GEU: hit = !lt_u;
      default: hit = 1'b0;
    endcase
  end

  // Equal operands are never ordered either way
  assert_eq_excludes_lt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eq |-> (!lt_s && !lt_u));

  // When signs differ, the negative operand is the signed-smaller one
  assert_sign_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a[XLEN-1] != b[XLEN-1]) |-> (lt_s == a[XLEN-1]));

  // When signs differ, signed and unsigned orderings disagree
  assert_order_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a[XLEN-1] != b[XLEN-1]) |-> (lt_s != lt_u));

endmodule

// File: rtl/bju_target.sv
module bju_target
  import bju_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned INSN_BYTES = 4
) (
  input  kind_e           kind,
  input  logic            hit,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] imm_b,
  input  logic [XLEN-1:0] imm_j,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] next_pc,
  output logic            taken,
  output logic            link_we,
  output logic [XLEN-1:0] link_val
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] seq_pc, ind_sum;

  assign seq_pc  = pc + STEP;
  assign ind_sum = a + imm_i;

  always_comb begin
    next_pc  = seq_pc;
    taken    = 1'b0;
    link_we  = 1'b0;
    link_val = '0;
    unique case (kind)
      K_BRANCH: begin
        if (hit) begin
          taken   = 1'b1;
          next_pc = pc + imm_b;
        end
      end
      K_DJUMP: begin
        taken    = 1'b1;
        next_pc  = pc + imm_j;
        link_we  = 1'b1;
        link_val = seq_pc;
      end
      K_IJUMP: begin
        taken    = 1'b1;
        next_pc  = {ind_sum[XLEN-1:1], 1'b0};
        link_we  = 1'b1;
        link_val = seq_pc;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bju_next_pc.sv
module bju_next_pc
  import bju_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_val_o,
  output logic            illegal_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  kind_e           kind;
  cmp_e            cmp;
  logic            bad_enc, hit, taken_c, link_we_c;
  logic [XLEN-1:0] imm_b, imm_j, imm_i, next_c, link_c;
  logic            primed;

  bju_decode #(.XLEN(XLEN)) u_dec (
    .insn(insn_i), .kind(kind), .cmp(cmp), .bad_enc(bad_enc),
    .imm_b(imm_b), .imm_j(imm_j), .imm_i(imm_i)
  );

  bju_cond_eval #(.XLEN(XLEN)) u_cmp (
    .clk(clk), .rst_n(rst_n), .a(src_a_i), .b(src_b_i), .cmp(cmp), .hit(hit)
  );

  bju_target #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_tgt (
    .kind(kind), .hit(hit), .pc(pc_i), .a(src_a_i),
    .imm_b(imm_b), .imm_j(imm_j), .imm_i(imm_i),
    .next_pc(next_c), .taken(taken_c), .link_we(link_we_c), .link_val(link_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc_o  <= '0;
      taken_o    <= 1'b0;
      link_we_o  <= 1'b0;
      link_val_o <= '0;
      illegal_o  <= 1'b0;
      primed     <= 1'b0;
    end else begin
      next_pc_o  <= next_c;
      taken_o    <= taken_c;
      link_we_o  <= link_we_c;
      link_val_o <= link_c;
      illegal_o  <= bad_enc;
      primed     <= 1'b1;
    end
  end

  assert_link_needs_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> taken_o);

  assert_link_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && link_we_o) |-> (link_val_o == $past(pc_i) + STEP));

  assert_fallthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !taken_o) |-> (next_pc_o == $past(pc_i) + STEP));

  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!taken_o && !link_we_o));

  assert_ind_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(insn_i[6:0]) == OPC_IJUMP && taken_o) |-> !next_pc_o[0]);

endmodule

// File: tb/tb_bju_next_pc.sv
module tb_bju_next_pc;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] insn;
  logic [63:0] pc, sa, sb;
  logic [63:0] next_pc, link_val;
  logic        taken, link_we, illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bju_next_pc dut (
    .clk(clk), .rst_n(rst_n), .insn_i(insn), .pc_i(pc),
    .src_a_i(sa), .src_b_i(sb), .next_pc_o(next_pc), .taken_o(taken),
    .link_we_o(link_we), .link_val_o(link_val), .illegal_o(illegal)
  );

  function automatic logic [31:0] enc_b(input logic [12:0] off, input logic [2:0] f3);
    return {off[12], off[10:5], 5'd3, 5'd9, f3, off[4:1], off[11], 7'h63};
  endfunction

  function automatic logic [31:0] enc_j(input logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], 5'd1, 7'h6f};
  endfunction

  function automatic logic [31:0] enc_i(input logic [11:0] off, input logic [2:0] f3);
    return {off, 5'd6, f3, 5'd1, 7'h67};
  endfunction

  function automatic bit br_cond(input logic [2:0] f3, input logic [63:0] a, input logic [63:0] b);
    case (f3)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) < $signed(b);
      3'd5: return !($signed(a) < $signed(b));
      3'd6: return a < b;
      3'd7: return !(a < b);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk64(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] w, input logic [63:0] p,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] e_next, input bit e_taken, input bit e_we,
                       input logic [63:0] e_link, input bit e_ill);
    insn = w; pc = p; sa = a; sb = b;
    @(negedge clk);
    chk64(tag, "next_pc", next_pc, e_next);
    chk64(tag, "taken", 64'(taken), 64'(e_taken));
    chk64(tag, "link_we", 64'(link_we), 64'(e_we));
    chk64(tag, "link_val", link_val, e_link);
    chk64(tag, "illegal", 64'(illegal), 64'(e_ill));
  endtask

  task automatic do_branch(input string tag, input logic [12:0] off, input logic [2:0] f3,
                           input logic [63:0] p, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] tgt;
    bit t;
    tgt = p + {{51{off[12]}}, off};
    t = br_cond(f3, a, b);
    apply(tag, enc_b(off, f3), p, a, b, t ? tgt : p + 64'd4, t, 1'b0, 64'd0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd24601));
    rst_n = 1'b0;
    insn = enc_j(21'h00010); pc = 64'h1000; sa = 64'd5; sb = 64'd5;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    chk64("R1", "next_pc", next_pc, 64'd0);
    chk64("R1", "taken", 64'(taken), 64'd0);
    chk64("R1", "link_we", 64'(link_we), 64'd0);
    chk64("R1", "illegal", 64'(illegal), 64'd0);
    rst_n = 1'b1;

    // R11: one cycle latency, the jump applied during reset now shows
    apply("R11", enc_j(21'h00010), 64'h1000, 0, 0, 64'h1010, 1, 1, 64'h1004, 0);
    // R2 equality pair
    do_branch("R2", 13'h010, 3'd0, 64'h2000, 64'h55, 64'h55);
    do_branch("R2", 13'h010, 3'd1, 64'h2000, 64'h55, 64'h55);
    do_branch("R2", 13'h010, 3'd1, 64'h2000, 64'h55, 64'h56);
    // R3 signed across sign boundary
    do_branch("R3", 13'h020, 3'd4, 64'h3000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    do_branch("R3", 13'h020, 3'd5, 64'h3000, 64'd7, 64'd7);
    do_branch("R3", 13'h020, 3'd5, 64'h3000, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF);
    // R4 unsigned across sign boundary
    do_branch("R4", 13'h020, 3'd6, 64'h3000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    do_branch("R4", 13'h020, 3'd7, 64'h3000, 64'd9, 64'd9);
    // R5 extreme offsets: most negative and most positive
    apply("R5", enc_b(13'h1000, 3'd0), 64'h8000, 1, 1, 64'h7000, 1, 0, 0, 0);
    apply("R5", enc_b(13'h0FFE, 3'd0), 64'h8000, 1, 1, 64'h8FFE, 1, 0, 0, 0);
    // R8 extreme jump offsets
    apply("R8", enc_j(21'h100000), 64'h0010_0000, 0, 0, 64'h0, 1, 1, 64'h0010_0004, 0);
    apply("R8", enc_j(21'h0FFFFE), 64'h40, 0, 0, 64'h0010_003E, 1, 1, 64'h44, 0);
    // R9 odd sum gets bit 0 cleared; negative offset
    apply("R9", enc_i(12'h001, 3'd0), 64'h500, 64'h1000, 0, 64'h1000, 1, 1, 64'h504, 0);
    apply("R9", enc_i(12'hFFF, 3'd0), 64'h500, 64'h1000, 0, 64'h0FFE, 1, 1, 64'h504, 0);
    // R10 illegal encodings
    apply("R10", enc_b(13'h040, 3'd2), 64'h600, 3, 3, 64'h604, 0, 0, 0, 1);
    apply("R10", enc_b(13'h040, 3'd3), 64'h600, 3, 4, 64'h604, 0, 0, 0, 1);
    apply("R10", enc_i(12'h040, 3'd5), 64'h600, 64'h80, 0, 64'h604, 0, 0, 0, 1);
    // R6 non-control opcode
    apply("R6", 32'h0030_0093, 64'h700, 1, 2, 64'h704, 0, 0, 0, 0);

    for (int n = 0; n < 400; n++) begin
      logic [63:0] p, a, b;
      int k;
      p = {$urandom, $urandom} & ~64'h3;
      a = {$urandom, $urandom};
      b = ($urandom % 4 == 0) ? a : {$urandom, $urandom};
      k = $urandom % 6;
      case (k)
        0: begin
          logic [2:0] f3;
          f3 = 3'($urandom);
          if (f3 == 3'd2 || f3 == 3'd3) f3 = 3'd7;
          do_branch(f3 <= 3'd1 ? "R2" : (f3 <= 3'd5 ? "R3" : "R4"),
                    {12'($urandom), 1'b0}, f3, p, a, b);
        end
        1: begin
          logic [12:0] o;
          o = {12'($urandom), 1'b0};
          apply("R10", enc_b(o, 3'd2 + 3'($urandom % 2)), p, a, b, p + 4, 0, 0, 0, 1);
        end
        2: begin
          logic [20:0] o;
          o = {20'($urandom), 1'b0};
          apply("R8", enc_j(o), p, a, b, p + {{43{o[20]}}, o}, 1, 1, p + 4, 0);
        end
        3: begin
          logic [11:0] o;
          logic [63:0] s;
          o = 12'($urandom);
          s = a + {{52{o[11]}}, o};
          apply("R9", enc_i(o, 3'd0), p, a, b, {s[63:1], 1'b0}, 1, 1, p + 4, 0);
        end
        4: begin
          logic [2:0] f3;
          f3 = 3'd1 + 3'($urandom % 7);
          apply("R10", enc_i(12'($urandom), f3), p, a, b, p + 4, 0, 0, 0, 1);
        end
        default: begin
          logic [31:0] w;
          w = $urandom;
          w[6:0] = 7'h33;
          apply("R6", w, p, a, b, p + 4, 0, 0, 0, 0);
        end
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule